// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block arbitrates interrupt requests for a small 16-bit CPU. It has a fixed set of priority slots, 32 by default. Each slot has a word-aligned vector address in the top 64 bytes of the address space, and a slot's vector is `0xFFC0 + 2 × slot`. The highest slot holds the reset vector at `0xFFFE`. The next slot down is the non-maskable slot at `0xFFFC`. Every remaining slot is maskable.

The block takes the following inputs:
- a request line and an enable line for each maskable slot;
- a set of non-maskable source flags, each with its own enable;
- reset causes from an external pin, a watchdog timeout and a flash key violation;
- the CPU's instruction fetch address;
- the word read back from the reset vector.

The CPU runs the acknowledge. It asserts `insn_boundary` when it can accept an interrupt. The block then pulses `irq_ack` for one cycle and presents the chosen vector on `vec_addr`. The vector stays unchanged until the next accept or reset.

The block also makes resets of its own:
- A fetch from the low peripheral-register region forces a reset.
- A fetch from the configured unused gap also forces a reset.
- If the reset vector reads back as erased (`0xFFFF`), the block requests the deepest sleep mode instead of letting the CPU run.

A sticky status word records every reset cause seen since the last power-up.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After power-up reset (`rst` high), the outputs take these values: `irq_ack`=0, `sys_reset`=0, `gie`=0, `sleep_req`=0, `vec_addr`=0xFFFE and `rst_cause`=5'b00001.
- R2: An accepted request for slot s puts `vec_addr` = 0xFFC0 + 2·s. The slot index is the bit position of the request in `irq_req`, and the non-maskable slot is 30.
- R3: When several slots are pending at an accept, the slot with the highest index wins.
- R4: Maskable slot s (0..29) is accepted only when all four of `irq_req[s]`, `irq_en[s]`, `gie` and `insn_boundary` are 1 at the clock edge.
- R5: The non-maskable slot is armed one edge after any `nmi_flag[i] & nmi_en[i]` becomes 1. It is taken once per such rise and ignores `gie`, but it still waits for `insn_boundary`.
- R6: `irq_ack` is high for exactly the one cycle after the accepting edge, and `gie` reads 0 in that cycle. A `gie_set` pulse makes `gie` read 1 after the next edge.
- R7: `vec_addr` does not change in any cycle that follows neither an accept nor a reset event.
- R8: A reset event (`rst_pin`, `wdt_expire`, `key_viol` or a fetch fault) produces a one-cycle `sys_reset` after the edge, with `vec_addr`=0xFFFE, `irq_ack`=0 and `gie`=0, even when a maskable request would also have been accepted.
- R9: A fetch fault is `fetch_valid` with `fetch_addr` < 0x0200, or with `fetch_addr` in 0x0400..0xBFFF inclusive.
- R10: `rst_cause` bits are {fetch, key, wdt, pin, power-up} from bit 4 down to bit 0. Each bit is sticky, and only `rst` clears the word back to 5'b00001.
- R11: `sleep_req` is set by `rstvec_valid` with `rstvec_word`=0xFFFF, and cleared by `rstvec_valid` with any other word, or by `rst`.
- R12: Maskable requests are level-sensitive. A request still held after `gie` is set again is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| irq_req | input | 30 | Maskable request per slot 0..29 (OR of that slot's flags) |
| irq_en | input | 30 | Per-slot enable for the maskable requests |
| nmi_flag | input | 3 | Non-maskable source flags |
| nmi_en | input | 3 | Individual enables for the non-maskable sources |
| gie_set | input | 1 | Software pulse that sets the global interrupt enable |
| insn_boundary | input | 1 | The CPU can accept an interrupt this cycle |
| rst_pin | input | 1 | External reset request |
| wdt_expire | input | 1 | Watchdog timeout |
| key_viol | input | 1 | Flash key violation |
| fetch_valid | input | 1 | An instruction fetch is under way |
| fetch_addr | input | 16 | Instruction fetch address |
| rstvec_valid | input | 1 | `rstvec_word` holds the word read from 0xFFFE |
| rstvec_word | input | 16 | Reset vector contents |
| irq_ack | output | 1 | One-cycle accept strobe |
| vec_addr | output | 16 | Vector table address for the CPU to fetch |
| gie | output | 1 | Global interrupt enable |
| sys_reset | output | 1 | One-cycle system reset request |
| sleep_req | output | 1 | Deepest low-power request |
| rst_cause | output | 5 | Sticky reset cause bits |

## Verification
A corrupted arbitration result shows up at the ports within one cycle of the accepting edge. The wrong slot appears as a `vec_addr` that differs from 0xFFC0 + 2·slot, or as a missing or doubled `irq_ack`. A stuck global enable shows on the `gie` port in the cycle after an accept. It also shows as a repeated acknowledge when a level request is still held. A wrong fetch-window comparison or a lost cause bit shows one cycle after the offending fetch, on `sys_reset` and `rst_cause`. An erased-vector check that never clears stays visible on `sleep_req` after the next valid read.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    // Decision taken at a clock edge
    typedef enum logic [1:0] {
        TAKE_NONE  = 2'd0,
        TAKE_MASK  = 2'd1,
        TAKE_NMI   = 2'd2,
        TAKE_RESET = 2'd3
    } take_e;

    // Reset cause word, power-up in bit 0
    typedef struct packed {
        logic fetch;
        logic key;
        logic wdt;
        logic pin;
        logic por;
    } rst_cause_t;

    localparam rst_cause_t CAUSE_POR = '{fetch: 1'b0, key: 1'b0, wdt: 1'b0, pin: 1'b0, por: 1'b1};

    // True when addr falls in [lo, hi]
    function automatic logic in_window(input logic [15:0] addr,
                                       input logic [15:0] lo,
                                       input logic [15:0] hi);
        return (addr >= lo) && (addr <= hi);
    endfunction

endpackage

// File: rtl/irq_fetch_guard.sv
module irq_fetch_guard #(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] REG_LIMIT = 'h0200,
    parameter logic [ADDR_W-1:0] GAP_LO    = 'h0400,
    parameter logic [ADDR_W-1:0] GAP_HI    = 'hBFFF
) (
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fault
);
    logic in_regs;
    logic in_gap;

    assign in_regs = fetch_addr < REG_LIMIT;
    assign in_gap  = (fetch_addr >= GAP_LO) && (fetch_addr <= GAP_HI);
    assign fault   = fetch_valid && (in_regs || in_gap);
endmodule

// File: rtl/irq_reset_ctl.sv
module irq_reset_ctl
    import irq_vec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_pin,
    input  logic       wdt_expire,
    input  logic       key_viol,
    input  logic       fetch_fault,
    output logic       rst_evt,
    output logic       sys_reset,
    output rst_cause_t cause
);
    rst_cause_t seen;

    always_comb begin
        seen       = '0;
        seen.pin   = rst_pin;
        seen.wdt   = wdt_expire;
        seen.key   = key_viol;
        seen.fetch = fetch_fault;
    end

    assign rst_evt = |seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_reset <= 1'b0;
            cause     <= CAUSE_POR;
        end else begin
            sys_reset <= rst_evt;
            cause     <= cause | seen;
        end
    end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N     = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Later (higher) indices overwrite earlier ones: highest pending wins
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int               NUM_SLOTS = 32,
    parameter int               ADDR_W    = 16,
    parameter int               NMI_SRCS  = 3,
    parameter logic [ADDR_W-1:0] REG_LIMIT = 'h0200,
    parameter logic [ADDR_W-1:0] GAP_LO    = 'h0400,
    parameter logic [ADDR_W-1:0] GAP_HI    = 'hBFFF,
    localparam int MASK_SLOTS = NUM_SLOTS - 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MASK_SLOTS-1:0] irq_req,
    input  logic [MASK_SLOTS-1:0] irq_en,
    input  logic [NMI_SRCS-1:0]   nmi_flag,
    input  logic [NMI_SRCS-1:0]   nmi_en,
    input  logic                  gie_set,
    input  logic                  insn_boundary,
    input  logic                  rst_pin,
    input  logic                  wdt_expire,
    input  logic                  key_viol,
    input  logic                  fetch_valid,
    input  logic [ADDR_W-1:0]     fetch_addr,
    input  logic                  rstvec_valid,
    input  logic [ADDR_W-1:0]     rstvec_word,
    output logic                  irq_ack,
    output logic [ADDR_W-1:0]     vec_addr,
    output logic                  gie,
    output logic                  sys_reset,
    output logic                  sleep_req,
    output logic [4:0]            rst_cause
);
    localparam int IDX_W      = $clog2(NUM_SLOTS);
    localparam int RESET_SLOT = NUM_SLOTS - 1;
    localparam int NMI_SLOT   = NUM_SLOTS - 2;
    localparam logic [ADDR_W-1:0] VEC_BASE  = ADDR_W'((1 << ADDR_W) - 2 * NUM_SLOTS);
    localparam logic [ADDR_W-1:0] RESET_VEC = VEC_BASE + ADDR_W'(2 * RESET_SLOT);

    logic              fetch_fault;
    logic              rst_evt;
    rst_cause_t        cause;
    logic [NUM_SLOTS-1:0] pend;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic              gie_q;
    logic              nmi_q;
    logic              nmi_arm;
    logic              nmi_any;
    logic              nmi_rise;
    logic              ack_q;
    logic [ADDR_W-1:0] vec_q;
    logic [ADDR_W-1:0] vec_next;
    logic              sleep_q;
    take_e             take;

    irq_fetch_guard #(
        .ADDR_W   (ADDR_W),
        .REG_LIMIT(REG_LIMIT),
        .GAP_LO   (GAP_LO),
        .GAP_HI   (GAP_HI)
    ) u_guard (
        .fetch_valid(fetch_valid),
        .fetch_addr (fetch_addr),
        .fault      (fetch_fault)
    );

    irq_reset_ctl u_rstc (
        .clk        (clk),
        .rst        (rst),
        .rst_pin    (rst_pin),
        .wdt_expire (wdt_expire),
        .key_viol   (key_viol),
        .fetch_fault(fetch_fault),
        .rst_evt    (rst_evt),
        .sys_reset  (sys_reset),
        .cause      (cause)
    );

    // Non-maskable combined request, edge-armed
    assign nmi_any  = |(nmi_flag & nmi_en);
    assign nmi_rise = nmi_any && !nmi_q;

    // Per-slot pending vector
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pend
        if (s == RESET_SLOT) begin : g_rst
            assign pend[s] = 1'b0;
        end else if (s == NMI_SLOT) begin : g_nmi
            assign pend[s] = nmi_arm;
        end else begin : g_mask
            assign pend[s] = irq_req[s] & irq_en[s] & gie_q;
        end
    end

    irq_prio_arb #(.N(NUM_SLOTS)) u_arb (
        .pend (pend),
        .valid(win_valid),
        .idx  (win_idx)
    );

    assign vec_next = VEC_BASE + (ADDR_W'(win_idx) << 1);

    always_comb begin
        take = TAKE_NONE;
        if (rst_evt) begin
            take = TAKE_RESET;
        end else if (insn_boundary && win_valid) begin
            take = (int'(win_idx) == NMI_SLOT) ? TAKE_NMI : TAKE_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q   <= 1'b0;
            nmi_q   <= 1'b0;
            nmi_arm <= 1'b0;
            ack_q   <= 1'b0;
            vec_q   <= RESET_VEC;
            sleep_q <= 1'b0;
        end else begin
            nmi_q <= nmi_any;
            ack_q <= (take == TAKE_MASK) || (take == TAKE_NMI);
            unique case (take)
                TAKE_RESET: begin
                    vec_q   <= RESET_VEC;
                    gie_q   <= 1'b0;
                    nmi_arm <= 1'b0;
                end
                TAKE_NMI: begin
                    vec_q   <= vec_next;
                    gie_q   <= 1'b0;
                    nmi_arm <= 1'b0;
                end
                TAKE_MASK: begin
                    vec_q   <= vec_next;
                    gie_q   <= 1'b0;
                    nmi_arm <= nmi_arm | nmi_rise;
                end
                default: begin
                    gie_q   <= gie_q | gie_set;
                    nmi_arm <= nmi_arm | nmi_rise;
                end
            endcase
            if (rstvec_valid) begin
                sleep_q <= (rstvec_word == '1);
            end
        end
    end

    assign irq_ack   = ack_q;
    assign vec_addr  = vec_q;
    assign gie       = gie_q;
    assign sleep_req = sleep_q;
    assign rst_cause = cause;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_ack,
    input logic              sys_reset,
    input logic              gie,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [4:0]        rst_cause
);
    localparam logic [ADDR_W-1:0] VEC_BASE = ADDR_W'((1 << ADDR_W) - 2 * NUM_SLOTS);
    localparam logic [ADDR_W-1:0] TOP_VEC  = VEC_BASE + ADDR_W'(2 * (NUM_SLOTS - 1));

    p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    p_gie_low_on_ack_r6: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> !gie);

    p_vec_in_table_r2: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (vec_addr[0] == 1'b0 && vec_addr >= VEC_BASE && vec_addr != TOP_VEC));

    p_reset_vec_r8: assert property (@(posedge clk) disable iff (rst)
        sys_reset |-> (vec_addr == TOP_VEC && !irq_ack && !gie));

    p_vec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!irq_ack && !sys_reset && !$past(rst)) |-> $stable(vec_addr));

    p_cause_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((rst_cause & $past(rst_cause)) == $past(rst_cause)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_ack  (irq_ack),
    .sys_reset(sys_reset),
    .gie      (gie),
    .vec_addr (vec_addr),
    .rst_cause(rst_cause)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MS = 30;

    logic clk = 1'b0;
    logic rst;
    logic [MS-1:0] irq_req, irq_en;
    logic [2:0] nmi_flag, nmi_en;
    logic gie_set, insn_boundary, rst_pin, wdt_expire, key_viol;
    logic fetch_valid, rstvec_valid;
    logic [15:0] fetch_addr, rstvec_word;
    logic irq_ack, gie, sys_reset, sleep_req;
    logic [15:0] vec_addr;
    logic [4:0] rst_cause;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
        .nmi_flag(nmi_flag), .nmi_en(nmi_en), .gie_set(gie_set),
        .insn_boundary(insn_boundary), .rst_pin(rst_pin), .wdt_expire(wdt_expire),
        .key_viol(key_viol), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .rstvec_valid(rstvec_valid), .rstvec_word(rstvec_word),
        .irq_ack(irq_ack), .vec_addr(vec_addr), .gie(gie),
        .sys_reset(sys_reset), .sleep_req(sleep_req), .rst_cause(rst_cause)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear();
        irq_req = '0; irq_en = '0; nmi_flag = '0; nmi_en = '0;
        gie_set = 0; insn_boundary = 1; rst_pin = 0; wdt_expire = 0; key_viol = 0;
        fetch_valid = 0; fetch_addr = 16'h8000; rstvec_valid = 0; rstvec_word = 0;
    endtask

    task automatic do_rst();
        clear();
        rst = 1; step(); step(); rst = 0;
    endtask

    task automatic set_gie();
        gie_set = 1; step(); gie_set = 0;
    endtask

    initial begin
        do_rst();
        // R1 reset state
        chk(irq_ack == 0, "R1 ack", 32'(irq_ack), 0);
        chk(sys_reset == 0, "R1 sys_reset", 32'(sys_reset), 0);
        chk(gie == 0, "R1 gie", 32'(gie), 0);
        chk(sleep_req == 0, "R1 sleep", 32'(sleep_req), 0);
        chk(vec_addr == 16'hFFFE, "R1 vec", 32'(vec_addr), 32'hFFFE);
        chk(rst_cause == 5'b00001, "R1 cause", 32'(rst_cause), 1);

        // R4/R2/R6: single-slot sweep over gie and enable
        for (int s = 0; s < MS; s++) begin
            for (int c = 0; c < 4; c++) begin
                do_rst();
                if (c[0]) begin
                    set_gie();
                    chk(gie == 1, "R6 gie_set", 32'(gie), 1);
                end
                irq_req[s] = 1'b1;
                irq_en[s]  = c[1];
                step();
                chk(irq_ack == (c == 3), "R4 gated accept", 32'(irq_ack), 32'(c == 3));
                if (c == 3) begin
                    chk(vec_addr == 16'(16'hFFC0 + 2 * s), "R2 vector", 32'(vec_addr), 32'(16'hFFC0 + 2 * s));
                    chk(gie == 0, "R6 gie cleared", 32'(gie), 0);
                    step();
                    chk(irq_ack == 0, "R6 one-cycle ack", 32'(irq_ack), 0);
                end
            end
        end

        // R3: every pair of maskable slots
        do_rst();
        irq_en = '1;
        for (int a = 0; a < MS; a++) begin
            for (int b = a + 1; b < MS; b++) begin
                irq_req = '0;
                set_gie();
                irq_req[a] = 1'b1;
                irq_req[b] = 1'b1;
                step();
                chk(irq_ack == 1 && vec_addr == 16'(16'hFFC0 + 2 * b), "R3 priority",
                    32'(vec_addr), 32'(16'hFFC0 + 2 * b));
                irq_req = '0;
                step();
                chk(irq_ack == 0, "R6 ack drop", 32'(irq_ack), 0);
            end
        end

        // R12 + R7: level request retaken after gie set again, vector held meanwhile
        do_rst();
        set_gie();
        irq_req[7] = 1; irq_en[7] = 1;
        step();
        chk(irq_ack == 1 && vec_addr == 16'hFFCE, "R12 first take", 32'(vec_addr), 32'hFFCE);
        irq_req[7] = 0; irq_req[3] = 1; irq_en[3] = 1;
        step(); step();
        chk(vec_addr == 16'hFFCE && irq_ack == 0, "R7 vector held", 32'(vec_addr), 32'hFFCE);
        irq_req[3] = 0; irq_req[7] = 1;
        gie_set = 1; step(); gie_set = 0;
        chk(irq_ack == 0, "R12 no take on set edge", 32'(irq_ack), 0);
        step();
        chk(irq_ack == 1 && vec_addr == 16'hFFCE, "R12 retaken", 32'(vec_addr), 32'hFFCE);

        // R5: NMI ignores gie, taken once per rise, obeys its own enable
        do_rst();
        nmi_flag = 3'b010; nmi_en = 3'b101;
        step(); step(); step();
        chk(irq_ack == 0, "R5 nmi disabled", 32'(irq_ack), 0);
        nmi_en = 3'b010;
        step();
        chk(irq_ack == 0, "R5 nmi arm cycle", 32'(irq_ack), 0);
        step();
        chk(irq_ack == 1 && vec_addr == 16'hFFFC, "R5 nmi taken gie=0", 32'(vec_addr), 32'hFFFC);
        step(); step();
        chk(irq_ack == 0, "R5 nmi once per rise", 32'(irq_ack), 0);
        nmi_en = 3'b000; step();
        nmi_en = 3'b010; step(); step();
        chk(irq_ack == 1 && vec_addr == 16'hFFFC, "R5 nmi re-rise", 32'(vec_addr), 32'hFFFC);

        // R5/R3/R4: armed NMI beats slot 29, waits for insn_boundary
        do_rst();
        set_gie();
        insn_boundary = 0;
        irq_req[29] = 1; irq_en[29] = 1;
        nmi_flag = 3'b001; nmi_en = 3'b001;
        step(); step();
        chk(irq_ack == 0, "R4 no boundary", 32'(irq_ack), 0);
        insn_boundary = 1;
        step();
        chk(irq_ack == 1 && vec_addr == 16'hFFFC, "R3 nmi over 29", 32'(vec_addr), 32'hFFFC);

        // R8: reset event wins over a ready request
        do_rst();
        set_gie();
        irq_req[5] = 1; irq_en[5] = 1; rst_pin = 1;
        step();
        chk(sys_reset == 1 && irq_ack == 0, "R8 reset wins", 32'({sys_reset, irq_ack}), 32'b10);
        chk(vec_addr == 16'hFFFE && gie == 0, "R8 reset vector", 32'(vec_addr), 32'hFFFE);
        chk(rst_cause == 5'b00011, "R10 pin cause", 32'(rst_cause), 32'h3);
        rst_pin = 0; irq_req = '0;
        step();
        chk(sys_reset == 0, "R8 one-cycle reset", 32'(sys_reset), 0);

        // R10: sticky cause, cleared only by power-up reset
        wdt_expire = 1; step(); wdt_expire = 0;
        key_viol = 1; step(); key_viol = 0; step();
        chk(rst_cause == 5'b01111, "R10 sticky", 32'(rst_cause), 32'hF);
        do_rst();
        chk(rst_cause == 5'b00001, "R10 por clears", 32'(rst_cause), 1);

        // R9: fetch window sweep plus boundaries
        for (int i = 0; i < 520; i++) begin
            logic [15:0] fa;
            bit exp_f;
            fa = (i < 512) ? 16'(i * 128 + (i % 7)) :
                 (i == 512) ? 16'h01FF : (i == 513) ? 16'h0200 :
                 (i == 514) ? 16'h03FF : (i == 515) ? 16'h0400 :
                 (i == 516) ? 16'hBFFF : (i == 517) ? 16'hC000 :
                 (i == 518) ? 16'h0000 : 16'hFFFF;
            exp_f = (fa < 16'h0200) || (fa >= 16'h0400 && fa <= 16'hBFFF);
            fetch_valid = 1; fetch_addr = fa;
            step();
            chk(sys_reset == exp_f, "R9 fetch window", 32'({fa, 15'b0, sys_reset}), 32'({fa, 15'b0, exp_f}));
            if (exp_f) chk(rst_cause[4] == 1, "R10 fetch cause", 32'(rst_cause), 32'h10);
            fetch_valid = 0;
            step();
        end
        fetch_addr = 16'h0010; step();
        chk(sys_reset == 0, "R9 needs fetch_valid", 32'(sys_reset), 0);

        // R11: erased reset vector
        do_rst();
        rstvec_valid = 1; rstvec_word = 16'hFFFF; step();
        chk(sleep_req == 1, "R11 erased", 32'(sleep_req), 1);
        rstvec_valid = 0; rstvec_word = 16'h1234; step();
        chk(sleep_req == 1, "R11 hold", 32'(sleep_req), 1);
        rstvec_valid = 1; rstvec_word = 16'hFFFE; step();
        chk(sleep_req == 0, "R11 programmed", 32'(sleep_req), 0);
        rstvec_word = 16'hFFFF; step();
        rstvec_valid = 0;
        rst = 1; step(); rst = 0;
        chk(sleep_req == 0, "R11 rst clears", 32'(sleep_req), 0);

        summary();
    end
endmodule